// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes one DDR2 SDRAM rank from power-on to normal operation. A one-cycle `start` pulse, together with the rank geometry and a refresh setting, launches a fixed command sequence on the memory command/address pins. The sequence first waits a long stabilisation interval. It then issues precharge-all, loads the mode and extended mode registers with DLL enable and DLL reset, precharges again and runs two auto-refresh cycles. Next it reloads the mode register, enters and leaves OCD default calibration, and finally hands over to normal mode.

Alongside the pins, a 32-bit control word reports the geometry, the current operating mode and, once normal mode is reached, the refresh setting. Minimum spacings between commands are parameters. The mode-register payloads are also parameters, so the exact address values are known at build time. If the geometry is illegal, the block refuses to start and raises an error pulse.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `cfg_err` and `cke` are 0, `cs_n` is 1, `ctrl_word` is 0. A reset during a sequence returns the block to this idle state.
- R2: A start with `row_bits` outside 11..14 or `col_bits` outside 8..10 produces a one-cycle `cfg_err` pulse on the next cycle. No busy period and no command follow it.
- R3: A legal start raises `busy` and `cke` in the next cycle, with `cs_n` low. The first command appears exactly `STAB_CYC` cycles after the start edge. Every non-command cycle while busy is a NOP: `cs_n`=0 and `ras_n`/`cas_n`/`we_n`=1.
- R4: Exactly eleven commands are issued, in this order: precharge-all; load bank 2 (EMR2); load bank 3 (EMR3); load bank 1 (EMR1, DLL on); load bank 0 (MR with DLL reset); precharge-all; auto refresh; auto refresh; load bank 0 (MR); load bank 1 (EMR1 with OCD default); load bank 1 (EMR1, OCD exit).
- R5: The pin encodings {ras_n,cas_n,we_n} are: precharge = 010 with address bit 10 high and bank 0; auto refresh = 001 with address 0 and bank 0; mode-register load = 000.
- R6: The next command follows a precharge after exactly `T_RP` cycles, a mode-register load after exactly `T_MRD` cycles, and an auto refresh after exactly `T_RFC` cycles.
- R7: While each command is on the pins, `ctrl_word` holds: bit 31 = 1; bits 30:28 = mode (1 precharge, 2 auto refresh, 3 load register); bits 25:24 = row_bits−11; bits 21:20 = col_bits−8; bits 17:16 = dsize; all other bits 0.
- R8: Exactly `T_MRD` cycles after the last load, `ctrl_word` switches to mode 0 (normal), with `refresh` in bits 15:0. Before this point, bits 15:0 are 0.
- R9: `done` pulses for one cycle exactly `STAB_CYC` cycles after normal mode is entered. `busy` falls in that same cycle.
- R10: A `start` pulse while `busy` is high is ignored: the command stream, its timing and the latched geometry do not change.
- R11: Payloads: the first MR load (bank 0) carries `MR_BASE` with bit 8 set; the second carries `MR_BASE`. EMR1 loads (bank 1) carry `EMR1_BASE`, and the OCD-default load carries `EMR1_BASE` with bits 9:7 set. EMR2 and EMR3 carry `EMR2_VAL` and `EMR3_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin initialization |
| row_bits | input | 4 | Number of row address bits (legal 11..14) |
| col_bits | input | 4 | Number of column address bits (legal 8..10) |
| dsize | input | 2 | Data size code placed in the control word |
| refresh | input | 16 | Refresh setting merged at normal-mode entry |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus |
| ctrl_word | output | 32 | Enable, mode, geometry and refresh control word |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse on completion |
| cfg_err | output | 1 | One-cycle pulse on illegal geometry |

## Verification
Each run uses a random legal geometry, data size and refresh value. Every command is then compared cycle by cycle against a timeline computed in the bench. Because the geometry varies, a field placed in the wrong bits of the control word is exposed, as is a refresh value that leaks in before normal mode. Directed corners cover the row and column limits (11/14, 8/10) and the values just outside them (10/15, 7/11), which separate off-by-one legality checks. A start pulse injected mid-sequence with different geometry shows whether a busy sequencer relatches. A reset in mid-run confirms the return to idle.

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq #(
  parameter int ADDR_W    = 14,
  parameter int BANK_W    = 3,
  parameter int STAB_CYC  = 32'h20000,
  parameter int T_MRD     = 2,
  parameter int T_RP      = 4,
  parameter int T_RFC     = 26,
  parameter int MR_BASE   = 'h042,
  parameter int EMR1_BASE = 'h004,
  parameter int EMR2_VAL  = 'h000,
  parameter int EMR3_VAL  = 'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        row_bits,
  input  logic [3:0]        col_bits,
  input  logic [1:0]        dsize,
  input  logic [15:0]       refresh,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic [31:0]       ctrl_word,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  localparam int CNT_W = $clog2(STAB_CYC + T_MRD + T_RP + T_RFC + 1);
  localparam int MIN_GAP = (T_MRD < T_RP) ? ((T_MRD < T_RFC) ? T_MRD : T_RFC)
                                          : ((T_RP < T_RFC) ? T_RP : T_RFC);
  localparam logic [3:0] LAST_STEP = 4'd10;
  localparam logic [2:0] M_NORM = 3'd0, M_PRE = 3'd1, M_REF = 3'd2, M_LMR = 3'd3;

  typedef enum logic [1:0] {S_IDLE, S_STAB1, S_GAP, S_STAB2} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       step;
  logic [3:0]       nstep;
  logic [5:0]       geo_q;
  logic [15:0]      ref_q;
  logic [2:0]       s_mode;
  logic [2:0]       s_pins;
  logic [BANK_W-1:0] s_ba;
  logic [ADDR_W-1:0] s_addr;
  int               s_gap;
  logic             bad_geo;
  logic [1:0]       rsel, csel;

  assign bad_geo = (row_bits < 4'd11) || (row_bits > 4'd14) ||
                   (col_bits < 4'd8)  || (col_bits > 4'd10);
  assign rsel  = 2'(row_bits - 4'd11);
  assign csel  = 2'(col_bits - 4'd8);
  assign nstep = (state == S_GAP) ? step + 4'd1 : 4'd0;

  always_comb begin
    s_mode = M_LMR;
    s_ba   = '0;
    s_addr = '0;
    s_gap  = T_MRD;
    case (nstep)
      4'd0, 4'd5: begin s_mode = M_PRE; s_addr = ADDR_W'(1 << 10); s_gap = T_RP; end
      4'd1: begin s_ba = BANK_W'(2); s_addr = ADDR_W'(EMR2_VAL); end
      4'd2: begin s_ba = BANK_W'(3); s_addr = ADDR_W'(EMR3_VAL); end
      4'd3: begin s_ba = BANK_W'(1); s_addr = ADDR_W'(EMR1_BASE); end
      4'd4: s_addr = ADDR_W'(MR_BASE | (1 << 8));
      4'd6, 4'd7: begin s_mode = M_REF; s_gap = T_RFC; end
      4'd8: s_addr = ADDR_W'(MR_BASE);
      4'd9: begin s_ba = BANK_W'(1); s_addr = ADDR_W'(EMR1_BASE | (7 << 7)); end
      default: begin s_ba = BANK_W'(1); s_addr = ADDR_W'(EMR1_BASE); end
    endcase
    case (s_mode)
      M_PRE:   s_pins = 3'b010;
      M_REF:   s_pins = 3'b001;
      default: s_pins = 3'b000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0;
      step <= '0;
      geo_q <= '0;
      ref_q <= '0;
      cke <= 1'b0;
      cs_n <= 1'b1;
      {ras_n, cas_n, we_n} <= 3'b111;
      ba <= '0;
      addr <= '0;
      ctrl_word <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      done <= 1'b0;
      cfg_err <= 1'b0;
      {ras_n, cas_n, we_n} <= 3'b111;
      ba <= '0;
      addr <= '0;
      case (state)
        S_IDLE: if (start) begin
          if (bad_geo) cfg_err <= 1'b1;
          else begin
            geo_q <= {rsel, csel, dsize};
            ref_q <= refresh;
            busy  <= 1'b1;
            cke   <= 1'b1;
            cs_n  <= 1'b0;
            cnt   <= CNT_W'(STAB_CYC - 1);
            state <= S_STAB1;
          end
        end
        S_STAB1, S_GAP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (state == S_GAP && step == LAST_STEP) begin
            ctrl_word <= {1'b1, M_NORM, 2'b00, geo_q[5:4], 2'b00, geo_q[3:2],
                          2'b00, geo_q[1:0], ref_q};
            cnt   <= CNT_W'(STAB_CYC - 1);
            state <= S_STAB2;
          end else begin
            {ras_n, cas_n, we_n} <= s_pins;
            ba    <= s_ba;
            addr  <= s_addr;
            ctrl_word <= {1'b1, s_mode, 2'b00, geo_q[5:4], 2'b00, geo_q[3:2],
                          2'b00, geo_q[1:0], 16'h0000};
            cnt   <= CNT_W'(s_gap - 1);
            step  <= nstep;
            state <= S_GAP;
          end
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            done  <= 1'b1;
            busy  <= 1'b0;
            cs_n  <= 1'b1;
            state <= S_IDLE;
          end
        end
      endcase
    end
  end

  logic cmd_on;
  assign cmd_on = !cs_n && !(ras_n && cas_n && we_n);

  AST_BAD_GEOM: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bad_geo) |=> (cfg_err && !busy && cs_n)); // R2
  AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cke && !cs_n)); // R3
  AST_CMD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && MIN_GAP > 1) |=> !cmd_on); // R6
  AST_MODE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on |-> (ctrl_word[31] && ctrl_word[30:28] != M_NORM)); // R7
  AST_REF_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_word[30:28] != M_NORM) |-> (ctrl_word[15:0] == 16'h0)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(geo_q)); // R10
endmodule

// File: tb/ddr2_init_seq_tb.sv
`timescale 1ns/1ps
module ddr2_init_seq_tb;
  localparam int ADDR_W = 14, BANK_W = 3;
  localparam int STAB = 64, TMRD = 2, TRP = 3, TRFC = 9;
  localparam int MRB = 'h052, E1B = 'h044, E2V = 'h080, E3V = 'h000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] row_bits = 4'd11, col_bits = 4'd8;
  logic [1:0] dsize = '0;
  logic [15:0] refresh = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, busy, done, cfg_err;
  logic [BANK_W-1:0] ba;
  logic [ADDR_W-1:0] addr;
  logic [31:0] ctrl_word;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  ddr2_init_seq #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .STAB_CYC(STAB), .T_MRD(TMRD),
    .T_RP(TRP), .T_RFC(TRFC), .MR_BASE(MRB), .EMR1_BASE(E1B), .EMR2_VAL(E2V),
    .EMR3_VAL(E3V)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .row_bits(row_bits), .col_bits(col_bits),
    .dsize(dsize), .refresh(refresh), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ctrl_word(ctrl_word),
    .busy(busy), .done(done), .cfg_err(cfg_err));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int e_mode(int s);
    if (s == 0 || s == 5) return 1;
    if (s == 6 || s == 7) return 2;
    return 3;
  endfunction
  function automatic int e_pins(int s);
    case (e_mode(s)) 1: return 3'b010; 2: return 3'b001; default: return 3'b000; endcase
  endfunction
  function automatic int e_gap(int s);
    case (e_mode(s)) 1: return TRP; 2: return TRFC; default: return TMRD; endcase
  endfunction
  function automatic int e_ba(int s);
    case (s) 1: return 2; 2: return 3; 3, 9, 10: return 1; default: return 0; endcase
  endfunction
  function automatic int e_addr(int s);
    case (s)
      0, 5: return 1 << 10;
      1: return E2V;
      2: return E3V;
      3, 10: return E1B;
      4: return MRB | 'h100;
      8: return MRB;
      9: return E1B | 'h380;
      default: return 0;
    endcase
  endfunction
  function automatic logic [31:0] e_ctrl(int r, int c, int d, int m, int rf);
    return (32'h1 << 31) | (32'(m) << 28) | (32'(r - 11) << 24) |
           (32'(c - 8) << 20) | (32'(d) << 16) | 32'(rf);
  endfunction

  task automatic run_seq(input int r, input int c, input int d, input int rf, input int inj);
    int t[11];
    int t_norm, t_done, idx;
    bit nop_ok, extra_done;
    t[0] = STAB;
    for (int s = 1; s < 11; s++) t[s] = t[s-1] + e_gap(s - 1);
    t_norm = t[10] + TMRD;
    t_done = t_norm + STAB;
    idx = 0; nop_ok = 1; extra_done = 0;
    @(negedge clk);
    row_bits = 4'(r); col_bits = 4'(c); dsize = 2'(d); refresh = 16'(rf); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && cke && !cs_n, "R3", "busy/cke after start", {busy, cke, cs_n}, 3'b110);
    for (int k = 1; k <= t_done + 1; k++) begin
      @(negedge clk);
      if (!cs_n && !(ras_n && cas_n && we_n)) begin
        if (idx < 11) begin
          chk(k == t[idx], "R6", $sformatf("cycle of cmd %0d", idx), k, t[idx]);
          chk({ras_n, cas_n, we_n} == 3'(e_pins(idx)), "R5", $sformatf("pins cmd %0d", idx),
              {ras_n, cas_n, we_n}, e_pins(idx));
          chk(ba == BANK_W'(e_ba(idx)) && addr == ADDR_W'(e_addr(idx)), "R4 R11",
              $sformatf("ba/addr cmd %0d", idx), {ba, addr}, {BANK_W'(e_ba(idx)), ADDR_W'(e_addr(idx))});
          chk(ctrl_word == e_ctrl(r, c, d, e_mode(idx), 0), "R7",
              $sformatf("ctrl cmd %0d", idx), ctrl_word, e_ctrl(r, c, d, e_mode(idx), 0));
        end else chk(0, "R4", "extra command", idx, 11);
        idx++;
      end else if (busy && !(!cs_n && ras_n && cas_n && we_n)) nop_ok = 0;
      if (k == t_norm - 1)
        chk(ctrl_word[15:0] == 16'h0, "R8", "refresh before normal", ctrl_word[15:0], 0);
      if (k == t_norm)
        chk(ctrl_word == e_ctrl(r, c, d, 0, rf), "R8", "normal ctrl", ctrl_word, e_ctrl(r, c, d, 0, rf));
      if (k == t_done)
        chk(done && !busy, "R9", "done/busy at end", {done, busy}, 2'b10);
      else if (done) extra_done = 1;
      if (inj != 0 && k == inj) begin
        row_bits = 4'd14; col_bits = 4'd10; dsize = 2'd3; refresh = 16'hBEEF; start = 1'b1;
      end else start = 1'b0;
    end
    chk(idx == 11, "R4", "command count", idx, 11);
    chk(nop_ok, "R3", "NOP between commands", nop_ok, 1);
    chk(!extra_done, "R9", "done single pulse", extra_done, 0);
  endtask

  task automatic run_bad(input int r, input int c);
    bit quiet;
    quiet = 1;
    @(negedge clk);
    row_bits = 4'(r); col_bits = 4'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err && !busy, "R2", $sformatf("error pulse r%0d c%0d", r, c), {cfg_err, busy}, 2'b10);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy || cfg_err || !cs_n) quiet = 0;
    end
    chk(quiet, "R2", "no activity after bad geometry", quiet, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cfg_err && !cke && cs_n && ctrl_word == 0, "R1", "reset state",
        {busy, done, cfg_err, cke, cs_n}, 5'b00001);
    rst_n = 1'b1;
    run_seq(11, 8, 0, 'h1234, 0);
    run_seq(14, 10, 3, 'hFFFF, 0);
    run_bad(10, 9); run_bad(15, 9); run_bad(12, 7); run_bad(12, 11);
    run_seq(12, 9, 2, 'h0A5A, 20);
    for (int i = 0; i < 12; i++)
      run_seq($urandom_range(11, 14), $urandom_range(8, 10), $urandom_range(0, 3),
              $urandom_range(0, 16'hFFFF), (i % 3 == 0) ? $urandom_range(1, 90) : 0);
    @(negedge clk);
    row_bits = 4'd13; col_bits = 4'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && cs_n && !cke && ctrl_word == 0, "R1", "reset mid-sequence",
        {busy, cs_n, cke}, 3'b010);
    rst_n = 1'b1;
    run_seq(13, 9, 1, 'h0042, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule